// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block gathers sixteen interrupt sources into a single request line for a processor core. Eight of the sources arrive on active-low external pins and eight are internal active-high lines. One internal line can carry the output of a subordinate peripheral interrupt controller. Each external pin is configured on its own. It can be sensed either on a falling edge, in which case the event is latched, or as a live low level. It also has its own wakeup enable.

Every source passes through an enable bit before it can reach the core. A static priority encoder selects the lowest-numbered enabled pending source and reports its index together with a valid flag. A wake output rises whenever a wake-enabled external pin has an active request, regardless of the enable bits. Software reaches the configuration, the enables and the pending state through a small word-wide register port. It clears latched edge events by writing ones to the pending register.

Source numbering: sources 0 to 7 are external pins 0 to 7, and sources 8 to 15 are internal lines 0 to 7. Register addresses: 0 is the sense/wake configuration, 1 is the source enable, 2 is pending (read status, write one to clear) and 3 reads as zero.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset the configuration, enable and pending registers read 0, and irq_req, irq_code and wake are 0.
- R2: In the configuration register (address 0), bit 2k selects the sense of external pin k (1 = falling edge, 0 = low level). Bit 2k+1 is the wake enable of pin k. The register reads back what was written.
- R3: For a pin in edge mode, a falling edge sets pending bit k no later than three clock edges after the pin changes. The bit stays set after the pin returns high.
- R4: Writing 1 to pending bit k (address 2) clears a latched edge request, and writing 0 leaves it alone. A pin held low after the clear does not set the bit again until a new falling edge occurs.
- R5: For a pin in level mode, pending bit k follows the inverted pin after a two-flop synchronizer and is never latched. Writing 1 to such a bit has no effect.
- R6: Pending bits 8 to 15 follow internal lines 0 to 7 live, active high.
- R7: A source whose bit in the enable register (address 1) is 0 never drives irq_req or irq_code. Its pending bit is still visible.
- R8: irq_code is {1, index} of the lowest-numbered source that is both pending and enabled, or 5'b00000 when there is none. irq_req equals irq_code[4].
- R9: wake is 1 exactly when some external pin k has pending bit k set and wake enable bit 2k+1 set, independent of the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n | input | 8 | External request pins, active low, asynchronous |
| int_irq | input | 8 | Internal request lines, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| irq_req | output | 1 | Request to the core |
| irq_code | output | 5 | Bit 4 valid, bits 3:0 winning source index |
| wake | output | 1 | Wakeup request from low-power mode |

## Verification
Random runs with every pin in level mode and held steady compare the pending, winner and wake outputs against a reference model. The random enables separate masking faults from priority faults. Random edge runs drop a random subset of pins, check pending while the pins are low, and then raise the pins again. After the release, only the edge-configured pins may remain pending, which is what separates latched sensing from live sensing. Directed cases cover two more behaviours. A clear issued while the pin is still low shows that a clear is not undone without a fresh edge. A write of 1 to a level bit shows that such a write has no effect.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_EXT     = 8;
    localparam int NUM_INT     = 8;
    localparam int NUM_SRC     = NUM_EXT + NUM_INT;
    localparam int IDX_W       = $clog2(NUM_SRC);
    localparam int CFG_W       = 2 * NUM_EXT;
    localparam int DATA_W      = NUM_SRC;
    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_SENSE   = 2'd0,
        RA_ENABLE  = 2'd1,
        RA_PENDING = 2'd2,
        RA_SPARE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } win_t;

    function automatic logic [NUM_EXT-1:0] edge_bits(input logic [CFG_W-1:0] c);
        logic [NUM_EXT-1:0] r;
        for (int k = 0; k < NUM_EXT; k++) r[k] = c[2*k];
        return r;
    endfunction

    function automatic logic [NUM_EXT-1:0] wake_bits(input logic [CFG_W-1:0] c);
        logic [NUM_EXT-1:0] r;
        for (int k = 0; k < NUM_EXT; k++) r[k] = c[2*k+1];
        return r;
    endfunction
endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense
    import irq_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              latch_q;
    logic              fell;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_n};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fell = prev_q & ~sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || !edge_mode) latch_q <= 1'b0;
        else if (fell)         latch_q <= 1'b1;
        else if (clr)          latch_q <= 1'b0;
    end

    assign pend = edge_mode ? latch_q : ~sync_q[STAGES-1];
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output win_t               win
);
    always_comb begin
        win = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                win.valid = 1'b1;
                win.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_SRC-1:0]   pend,
    output logic [CFG_W-1:0]     cfg,
    output logic [NUM_SRC-1:0]   en,
    output logic [NUM_EXT-1:0]   clr,
    output logic [DATA_W-1:0]    rdata
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            en  <= '0;
        end else if (wr) begin
            if (sel == RA_SENSE)  cfg <= wdata;
            if (sel == RA_ENABLE) en  <= wdata;
        end
    end

    assign clr = (wr && sel == RA_PENDING) ? wdata[NUM_EXT-1:0] : '0;

    always_comb begin
        unique case (sel)
            RA_SENSE:   rdata = cfg;
            RA_ENABLE:  rdata = en;
            RA_PENDING: rdata = pend;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_EXT-1:0]   ext_irq_n,
    input  logic [NUM_INT-1:0]   int_irq,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_req,
    output logic [IDX_W:0]       irq_code,
    output logic                 wake
);
    logic [CFG_W-1:0]   cfg_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_EXT-1:0] clr_vec;
    logic [NUM_EXT-1:0] edge_sel;
    logic [NUM_SRC-1:0] live_vec;
    win_t               win;

    assign edge_sel = edge_bits(cfg_vec);

    irq_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .pend(pend_vec), .cfg(cfg_vec), .en(en_vec), .clr(clr_vec), .rdata(reg_rdata)
    );

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_pin
        irq_pin_sense #(.STAGES(SYNC_STAGES)) u_pin (
            .clk(clk), .rst(rst), .pin_n(ext_irq_n[k]), .edge_mode(edge_sel[k]),
            .clr(clr_vec[k]), .pend(pend_vec[k])
        );
    end

    assign pend_vec[NUM_SRC-1:NUM_EXT] = int_irq;
    assign live_vec = pend_vec & en_vec;

    irq_prio_enc u_enc (.req(live_vec), .win(win));

    assign irq_code = win;
    assign irq_req  = |live_vec;
    assign wake     = |(pend_vec[NUM_EXT-1:0] & wake_bits(cfg_vec));
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] en,
    input logic [CFG_W-1:0]   cfg,
    input logic               irq_req,
    input logic [IDX_W:0]     irq_code,
    input logic               wake
);
    logic [NUM_EXT-1:0] esel, wsel, clr_m;
    logic [NUM_SRC-1:0] above;

    always_comb begin
        esel  = edge_bits(cfg);
        wsel  = wake_bits(cfg);
        clr_m = (reg_wr && reg_addr == RA_PENDING) ? reg_wdata[NUM_EXT-1:0] : '0;
        above = (NUM_SRC'(1) << irq_code[IDX_W-1:0]) - NUM_SRC'(1);
    end

    AST_REQ_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
        irq_req == irq_code[IDX_W]); // R8

    AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (rst)
        irq_code[IDX_W] |-> (en[irq_code[IDX_W-1:0]] && pend[irq_code[IDX_W-1:0]])); // R7

    AST_NONE_ABOVE: assert property (@(posedge clk) disable iff (rst)
        irq_code[IDX_W] |-> ((pend & en & above) == '0)); // R8

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> (!irq_req && irq_code == '0)); // R7

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (($past(pend[NUM_EXT-1:0] & esel & ~clr_m) & esel & ~pend[NUM_EXT-1:0]) == '0)); // R3

    AST_WAKE_IGNORES_MASK: assert property (@(posedge clk) disable iff (rst)
        ((en == '0) && ((pend[NUM_EXT-1:0] & wsel) != '0)) |-> wake); // R9
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pend(pend_vec), .en(en_vec), .cfg(cfg_vec), .irq_req(irq_req),
    .irq_code(irq_code), .wake(wake)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    import irq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_EXT-1:0] ext_irq_n = '1;
    logic [NUM_INT-1:0] int_irq = '0;
    logic reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic irq_req, wake;
    logic [IDX_W:0] irq_code;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [CFG_W-1:0] cur_cfg = '0;
    logic [NUM_SRC-1:0] cur_en = '0;

    always #4 clk = ~clk;

    irq_prio_ctrl uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == RA_SENSE)  cur_cfg = d;
        if (a == RA_ENABLE) cur_en = d;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [IDX_W:0] f_code(input logic [NUM_SRC-1:0] live);
        logic [IDX_W:0] c = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) if (live[i]) c = {1'b1, IDX_W'(i)};
        return c;
    endfunction

    function automatic logic f_wake(input logic [NUM_SRC-1:0] p, input logic [CFG_W-1:0] c);
        logic w = 1'b0;
        for (int k = 0; k < NUM_EXT; k++) if (p[k] && c[2*k+1]) w = 1'b1;
        return w;
    endfunction

    task automatic check_all(input string tag, input logic [NUM_SRC-1:0] ep);
        logic [DATA_W-1:0] d;
        rd(RA_PENDING, d);
        chk({tag, " pending"}, d, ep);
        chk({tag, " R8 code"}, irq_code, f_code(ep & cur_en));
        chk({tag, " R8 req"}, irq_req, |(ep & cur_en));
        chk({tag, " R9 wake"}, wake, f_wake(ep, cur_cfg));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        void'($urandom(32'h1DEA5));
        settle(3);
        rst = 1'b0;
        settle(1);
        // R1 reset state
        rd(RA_SENSE, d);   chk("R1 cfg", d, 0);
        rd(RA_ENABLE, d);  chk("R1 en", d, 0);
        rd(RA_PENDING, d); chk("R1 pend", d, 0);
        chk("R1 req", irq_req, 0);
        chk("R1 code", irq_code, 0);
        chk("R1 wake", wake, 0);

        // R2 configuration read back
        wr(RA_SENSE, 16'hA5C3);
        rd(RA_SENSE, d); chk("R2 cfg readback", d, 16'hA5C3);
        rd(RA_SPARE, d); chk("R2 spare reads zero", d, 0);
        wr(RA_SENSE, 16'h0000);
        wr(RA_ENABLE, 16'hFFFF);
        rd(RA_ENABLE, d); chk("R7 en readback", d, 16'hFFFF);

        // R5 level mode: live, not latched, clear ignored
        ext_irq_n[3] = 1'b0; settle(4);
        check_all("R5 level low", 16'h0008);
        wr(RA_PENDING, 16'h0008); settle(1);
        check_all("R5 clear ignored", 16'h0008);
        ext_irq_n[3] = 1'b1; settle(4);
        check_all("R5 level gone", 16'h0000);

        // R3 edge latch on pin 5 with wake enable (bits 10, 11)
        wr(RA_SENSE, 16'h0C00);
        ext_irq_n[5] = 1'b0; settle(4);
        ext_irq_n[5] = 1'b1; settle(4);
        check_all("R3 edge held", 16'h0020);
        wr(RA_PENDING, 16'h0000); settle(1);
        check_all("R4 write zero keeps", 16'h0020);
        wr(RA_PENDING, 16'h0020); settle(1);
        check_all("R4 cleared", 16'h0000);
        ext_irq_n[5] = 1'b0; settle(4);
        check_all("R4 edge again", 16'h0020);
        wr(RA_PENDING, 16'h0020); settle(4);
        check_all("R4 held low no reset", 16'h0000);
        ext_irq_n[5] = 1'b1; settle(4);

        // R6 internal lines
        int_irq = 8'h81; settle(1);
        check_all("R6 internal", 16'h8100);

        // R7 masking, R9 wake independent of mask
        ext_irq_n[5] = 1'b0; settle(4);
        wr(RA_ENABLE, 16'h0000);
        check_all("R7 all masked", 16'h8120);
        chk("R9 wake with mask zero", wake, 1);

        // R8 priority: pin 5 masked, internal 8 wins
        wr(RA_ENABLE, 16'hFFDF);
        check_all("R8 skip masked", 16'h8120);
        chk("R8 winner is 8", irq_code, 5'h18);
        wr(RA_ENABLE, 16'hFFFF);
        chk("R8 winner is 5", irq_code, 5'h15);
        ext_irq_n[5] = 1'b1;
        wr(RA_PENDING, 16'h00FF);
        int_irq = '0; settle(4);

        // random, level mode, steady pins
        for (int it = 0; it < 40; it++) begin
            logic [NUM_EXT-1:0] pins = NUM_EXT'($urandom);
            logic [NUM_INT-1:0] ints = NUM_INT'($urandom);
            wr(RA_SENSE, CFG_W'($urandom) & 16'hAAAA);
            wr(RA_ENABLE, DATA_W'($urandom));
            ext_irq_n = pins; int_irq = ints; settle(4);
            check_all("R5 R7 R8 rand level", {ints, ~pins});
        end

        // random, mixed sense, drop then release
        for (int it = 0; it < 30; it++) begin
            logic [NUM_EXT-1:0] drop = NUM_EXT'($urandom);
            logic [NUM_INT-1:0] ints = NUM_INT'($urandom);
            logic [CFG_W-1:0] c = CFG_W'($urandom);
            ext_irq_n = '1; settle(4);
            wr(RA_SENSE, c);
            wr(RA_ENABLE, DATA_W'($urandom));
            wr(RA_PENDING, 16'h00FF);
            int_irq = ints;
            ext_irq_n = ~drop; settle(4);
            check_all("R3 R5 rand low", {ints, drop});
            ext_irq_n = '1; settle(4);
            check_all("R3 rand released", {ints, drop & edge_bits(c)});
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule